// File: doc/BRIEF.md
# Branch Condition Resolution Unit

This unit resolves control flow for a simple 32-bit load/store processor. Each cycle it receives one instruction word, the address of that instruction, and the two source operand values. Register zero reads as zero on the operand inputs. From these it decides whether a conditional branch is taken. It also computes the branch destination, produces the 0/1 result of a signed set-on-less-than instruction, and flags malformed zero-relative branch encodings. All four results are registered and appear one rising clock edge after the inputs.

Two-register branches only test whether the operands are equal or unequal. Ordered tests exist only against zero: "at most zero" and "above zero". A general signed less-than branch is built in two steps. A set-on-less-than instruction first writes 0 or 1 to a scratch register. A compare-with-register-zero branch then tests that register. The unit never cancels the instruction that follows a branch, because that delay-slot instruction always executes.

The register file, the rest of the ALU and hazard handling sit outside this block.

Top module: `br_resolve`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `take_q`=0, `slt_q`=0, `bad_enc_q`=0 and `target_q`=0.
- R2: For primary opcode `instr[31:26]`=6'b000100, `take_q` is 1 exactly when all 32 bits of `src_a` equal `src_b`. For opcode 6'b000101, `take_q` is 1 exactly when they differ.
- R3: For opcode 6'b000110, `take_q` is 1 when signed `src_a` is at most zero, meaning its sign bit is set or its value is zero. For opcode 6'b000111, `take_q` is 1 when its sign bit is clear and its value is nonzero. `src_b` has no effect on either.
- R4: For opcode 6'b000110 or 6'b000111 with the second register field `instr[20:16]` nonzero, `bad_enc_q` is 1 and `take_q` is 0.
- R5: For opcode 6'b000000 with function field `instr[5:0]`=6'b101010, `slt_q` is 1 when signed `src_a` < signed `src_b` and 0 otherwise. For every other instruction, `slt_q` is 0.
- R6: For the four branch opcodes, `target_q` = `pc` + 4 + (sign-extended `instr[15:0]` shifted left by 2). For example, `pc`=0x10 with offset 5 gives 0x28.
- R7: For any opcode that is not one of the four branch opcodes, `take_q` and `bad_enc_q` are 0.
- R8: Results appear on the first rising edge after the inputs. A taken branch has no effect on the result of the instruction presented in the next cycle, so the delay slot is never cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 32 | Instruction word being resolved |
| pc | input | 32 | Address of that instruction |
| src_a | input | 32 | First source operand value |
| src_b | input | 32 | Second source operand value |
| take_q | output | 1 | Branch taken, registered |
| target_q | output | 32 | Branch destination, registered |
| slt_q | output | 1 | Signed set-on-less-than result, registered |
| bad_enc_q | output | 1 | Malformed zero-relative branch, registered |

## Verification
The only state is the output register, so a wrong decode or compare shows up on the edge right after the offending inputs. It cannot be hidden later. The sign-sensitive cases are the ones most likely to expose a subtle fault: the most negative value, minus one, and zero, against both zero-relative tests and set-on-less-than. A stuck or leaked result in the output register would show on a back-to-back pair, a taken branch followed by an unrelated instruction, within one cycle.

// File: rtl/br_pkg.sv
// Package br_pkg
// Shared field widths, opcode values and the instruction class type used
// by the branch resolution unit. Assumes a fixed 32-bit instruction format
// with a 6-bit primary opcode in the top bits.
package br_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int IMM_W   = 16;
    localparam int FUNC_W  = 6;

    localparam logic [OPC_W-1:0]  OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0]  OPC_EQ    = 6'b000100;
    localparam logic [OPC_W-1:0]  OPC_NE    = 6'b000101;
    localparam logic [OPC_W-1:0]  OPC_LEZ   = 6'b000110;
    localparam logic [OPC_W-1:0]  OPC_GTZ   = 6'b000111;
    localparam logic [FUNC_W-1:0] FN_SLT    = 6'b101010;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_EQ,
        CLS_NE,
        CLS_LEZ,
        CLS_GTZ,
        CLS_SLT
    } instr_cls_e;

endpackage

// File: rtl/br_decode.sv
// Module br_decode
// Classifies an instruction word for branch resolution and extracts the
// immediate. Assumes the package field layout; any opcode not listed is
// reported as CLS_NONE. Purely combinational.
module br_decode
    import br_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output instr_cls_e         cls,
    output logic               rt_nonzero,
    output logic [IMM_W-1:0]   imm
);

    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RS_LSB  = OPC_LSB - REG_W;
    localparam int RT_LSB  = RS_LSB - REG_W;

    logic [OPC_W-1:0]  opc;
    logic [REG_W-1:0]  rt_fld;
    logic [FUNC_W-1:0] func;

    // Field extraction from the fixed instruction layout
    always_comb begin
        opc    = instr[INSTR_W-1:OPC_LSB];
        rt_fld = instr[RT_LSB+REG_W-1:RT_LSB];
        func   = instr[FUNC_W-1:0];
        imm    = instr[IMM_W-1:0];
    end

    // Second register field must be zero for zero-relative forms
    always_comb rt_nonzero = |rt_fld;

    // Map opcode and function code to an instruction class
    always_comb begin
        unique case (opc)
            OPC_EQ:    cls = CLS_EQ;
            OPC_NE:    cls = CLS_NE;
            OPC_LEZ:   cls = CLS_LEZ;
            OPC_GTZ:   cls = CLS_GTZ;
            OPC_RTYPE: cls = (func == FN_SLT) ? CLS_SLT : CLS_NONE;
            default:   cls = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/br_compare.sv
// Module br_compare
// Evaluates the branch condition, the signed set-on-less-than result and
// the illegal-encoding flag for one decoded instruction. Assumes register
// zero already reads as zero on the operand inputs. Combinational.
module br_compare
    import br_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  instr_cls_e          cls,
    input  logic                rt_nonzero,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    output logic                take,
    output logic                slt,
    output logic                bad_enc
);

    localparam int SGN = DATA_W - 1;

    logic a_eq_b;
    logic a_zero;
    logic a_neg;
    logic a_lt_b;

    // Shared comparator terms
    always_comb begin
        a_eq_b = (opa == opb);
        a_zero = ~|opa;
        a_neg  = opa[SGN];
        a_lt_b = $signed(opa) < $signed(opb);
    end

    // Illegal encoding: zero-relative branch naming a second register
    always_comb bad_enc = ((cls == CLS_LEZ) || (cls == CLS_GTZ)) && rt_nonzero;

    // Branch decision per class; a malformed encoding never branches
    always_comb begin
        unique case (cls)
            CLS_EQ:  take = a_eq_b;
            CLS_NE:  take = ~a_eq_b;
            CLS_LEZ: take = (a_neg | a_zero) & ~rt_nonzero;
            CLS_GTZ: take = ~a_neg & ~a_zero & ~rt_nonzero;
            default: take = 1'b0;
        endcase
    end

    // Set-on-less-than result, zero for every other class
    always_comb slt = (cls == CLS_SLT) & a_lt_b;

endmodule

// File: rtl/br_target.sv
// Module br_target
// Forms the branch destination: next sequential address plus the
// sign-extended word offset. Assumes word-aligned 4-byte instructions.
module br_target
    import br_pkg::*;
#(
    parameter int ADDR_W = 32
)(
    input  logic [ADDR_W-1:0] pc,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] target
);

    localparam int EXT_W = ADDR_W - IMM_W - 2;

    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] seq;

    // Word offset sign-extended and scaled to bytes
    always_comb offs = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};

    // Address of the delay-slot instruction
    always_comb seq = pc + ADDR_W'(4);

    // Destination sum
    always_comb target = seq + offs;

endmodule

// File: rtl/br_resolve.sv
// Module br_resolve
// Top of the branch resolution unit. Decodes, compares and computes the
// target combinationally, then registers all results on the rising edge.
// Assumes one instruction per cycle and synchronous active-low reset.
// Never cancels the following (delay-slot) instruction.
module br_resolve
    import br_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              take_q,
    output logic [ADDR_W-1:0] target_q,
    output logic              slt_q,
    output logic              bad_enc_q
);

    instr_cls_e        cls;
    logic              rt_nz;
    logic [IMM_W-1:0]  imm;
    logic              take_d;
    logic              slt_d;
    logic              bad_d;
    logic [ADDR_W-1:0] tgt_d;

    br_decode u_dec (
        .instr      (instr),
        .cls        (cls),
        .rt_nonzero (rt_nz),
        .imm        (imm)
    );

    br_compare #(.DATA_W(DATA_W)) u_cmp (
        .cls        (cls),
        .rt_nonzero (rt_nz),
        .opa        (src_a),
        .opb        (src_b),
        .take       (take_d),
        .slt        (slt_d),
        .bad_enc    (bad_d)
    );

    br_target #(.ADDR_W(ADDR_W)) u_tgt (
        .pc     (pc),
        .imm    (imm),
        .target (tgt_d)
    );

    // Output register with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q    <= 1'b0;
            slt_q     <= 1'b0;
            bad_enc_q <= 1'b0;
            target_q  <= '0;
        end else begin
            take_q    <= take_d;
            slt_q     <= slt_d;
            bad_enc_q <= bad_d;
            target_q  <= tgt_d;
        end
    end

endmodule

// File: rtl/br_resolve_chk.sv
// Module br_resolve_chk
// Port-level temporal checks for br_resolve, bound to every instance.
// Each property compares registered outputs with the inputs of the
// previous cycle, only when that previous cycle was out of reset.
module br_resolve_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
)(
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       instr,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              take_q,
    input logic [ADDR_W-1:0] target_q,
    input logic              slt_q,
    input logic              bad_enc_q
);

    logic is_br;
    logic is_zform;
    always_comb begin
        is_br    = (instr[31:28] == 4'b0001);
        is_zform = (instr[31:27] == 5'b00011);
    end

    AST_EQ_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[31:26]) == 6'b000100)
        |-> take_q == ($past(src_a) == $past(src_b)));            // R2

    AST_NE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[31:26]) == 6'b000101)
        |-> take_q == ($past(src_a) != $past(src_b)));            // R2

    AST_ZFORM_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(is_zform) && $past(instr[20:16]) != 5'd0)
        |-> (bad_enc_q && !take_q));                               // R4

    AST_TARGET_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(is_br))
        |-> target_q == $past(pc) + 32'd4
            + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}); // R6

    AST_NONBRANCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(is_br)) |-> (!take_q && !bad_enc_q)); // R7

    AST_SLT_ONLY_FOR_SLT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(instr[31:26]) != 6'b000000
                          || $past(instr[5:0]) != 6'b101010))
        |-> !slt_q);                                               // R5

endmodule

bind br_resolve br_resolve_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr     (instr),
    .pc        (pc),
    .src_a     (src_a),
    .src_b     (src_b),
    .take_q    (take_q),
    .target_q  (target_q),
    .slt_q     (slt_q),
    .bad_enc_q (bad_enc_q)
);

// File: tb/test_br_resolve.sv
module test_br_resolve;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        take_q;
    logic [31:0] target_q;
    logic        slt_q;
    logic        bad_enc_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    br_resolve i_br_resolve (
        .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc),
        .src_a(src_a), .src_b(src_b), .take_q(take_q),
        .target_q(target_q), .slt_q(slt_q), .bad_enc_q(bad_enc_q)
    );

    // Vector: instr, pc, a, b, expected target, take, slt, bad, check-target
    localparam int NV = 18;
    localparam logic [163:0] VEC [NV] = '{
        {32'h10220005, 32'h10,  32'h1234,     32'h1234,     32'h28,  4'b1001}, // R2 eq equal
        {32'h10220005, 32'h10,  32'h5,        32'h80000005, 32'h28,  4'b0001}, // R2 eq top bit differs
        {32'h14220005, 32'h10,  32'h5,        32'h80000005, 32'h28,  4'b1001}, // R2 ne differ
        {32'h14220005, 32'h10,  32'h77,       32'h77,       32'h28,  4'b0001}, // R2 ne equal
        {32'h1820FFFF, 32'h100, 32'h0,        32'h0,        32'h100, 4'b1001}, // R3 lez zero
        {32'h1820FFFF, 32'h100, 32'h80000000, 32'h0,        32'h100, 4'b1001}, // R3 lez most negative
        {32'h1820FFFF, 32'h100, 32'h1,        32'h0,        32'h100, 4'b0001}, // R3 lez one
        {32'h1C200010, 32'h200, 32'h1,        32'h0,        32'h244, 4'b1001}, // R3 gtz one
        {32'h1C200010, 32'h200, 32'h0,        32'h0,        32'h244, 4'b0001}, // R3 gtz zero
        {32'h1C200010, 32'h200, 32'hFFFFFFFF, 32'h0,        32'h244, 4'b0001}, // R3 gtz minus one
        {32'h1C200010, 32'h200, 32'h1,        32'hFFFFFFFF, 32'h244, 4'b1001}, // R3 src_b ignored
        {32'h1C230010, 32'h200, 32'h1,        32'h0,        32'h244, 4'b0011}, // R4 gtz rt=3
        {32'h1821FFFF, 32'h100, 32'h0,        32'h0,        32'h100, 4'b0011}, // R4 lez rt=1
        {32'h0022182A, 32'h300, 32'hFFFFFFFF, 32'h1,        32'h0,   4'b0100}, // R5 -1 < 1
        {32'h0022182A, 32'h300, 32'h1,        32'hFFFFFFFF, 32'h0,   4'b0000}, // R5 1 < -1 false
        {32'h0022182A, 32'h300, 32'h5,        32'h5,        32'h0,   4'b0000}, // R5 equal
        {32'h00221820, 32'h300, 32'hFFFFFFFF, 32'h1,        32'h0,   4'b0000}, // R5 R7 other funct
        {32'h8C220000, 32'h400, 32'h9,        32'h9,        32'h0,   4'b0000}  // R7 load opcode
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] i, input logic [31:0] p,
                         input logic [31:0] a, input logic [31:0] b);
        instr = i; pc = p; src_a = a; src_b = b;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        // R1: reset with a taken-branch pattern at the inputs
        drive(32'h10220005, 32'h10, 32'h3, 32'h3);
        repeat (3) @(negedge clk);
        chk("R1", "take", {31'b0, take_q}, 32'd0);
        chk("R1", "slt", {31'b0, slt_q}, 32'd0);
        chk("R1", "bad", {31'b0, bad_enc_q}, 32'd0);
        chk("R1", "target", target_q, 32'd0);
        rst_n = 1'b1;

        // Table walk: drive at a falling edge, check one edge later
        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][163:132], VEC[k][131:100], VEC[k][99:68], VEC[k][67:36]);
            @(negedge clk);
            chk("R2/R3/R4/R5/R7", $sformatf("vec%0d take", k), {31'b0, take_q}, {31'b0, VEC[k][3]});
            chk("R5", $sformatf("vec%0d slt", k), {31'b0, slt_q}, {31'b0, VEC[k][2]});
            chk("R4/R7", $sformatf("vec%0d bad", k), {31'b0, bad_enc_q}, {31'b0, VEC[k][1]});
            if (VEC[k][0])
                chk("R6", $sformatf("vec%0d target", k), target_q, VEC[k][35:4]);
        end

        // R6: negative offset and large positive offset
        drive(32'h10228000, 32'h00020000, 32'h0, 32'h0);
        @(negedge clk);
        chk("R6", "offset -32768", target_q, 32'h00000004);
        drive(32'h14217FFF, 32'h1000, 32'h1, 32'h2);
        @(negedge clk);
        chk("R6", "offset 32767", target_q, 32'h00021000);

        // R8: taken branch then set-on-less-than in the next cycle
        drive(32'h10220005, 32'h10, 32'h4, 32'h4);
        @(negedge clk);
        chk("R8", "branch taken", {31'b0, take_q}, 32'd1);
        drive(32'h0022182A, 32'h14, 32'h80000000, 32'h0);
        @(negedge clk);
        chk("R8", "slot slt", {31'b0, slt_q}, 32'd1);
        chk("R8", "slot take", {31'b0, take_q}, 32'd0);

        // R1: reset in mid-run clears a pending taken result
        drive(32'h10220005, 32'h10, 32'h4, 32'h4);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid-run take", {31'b0, take_q}, 32'd0);
        chk("R1", "mid-run target", target_q, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "after reset", {31'b0, take_q}, 32'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule